// File: doc/BRIEF.md
# Divided Clock-Enable Strobe Generator

The block sits in the main clock domain and turns two clock sources into one-cycle enable strobes. The rest of the chip qualifies its flops with these strobes, so it never needs a gated or derived clock. The auxiliary strobe is paced by a slow, asynchronous crystal input. That input is brought into the main domain through a flop chain and counted once per rising edge. The subsystem strobe is paced by the same slow input or by the main clock itself, chosen by a select bit. Each strobe has its own divider with ratios of 1, 2, 4 and 8.

Two byte-wide control registers set the dividers and the source select. They sit behind a simple port with write-enable, address, write data and combinational read data. An external run input halts both strobes and raises a freeze flag while it is low. While the block is halted the divider counters hold their values, so counting resumes from where it stopped.

Top module: `clk_strobe_gen`

## Requirements
- R1: In reset and straight after it, both strobes are low and both control registers read 0x00. Source select 0 means the main clock is the subsystem source.
- R2: Control register A is at address 0. Bits 5:4 hold the auxiliary divide code. After writing 0xFF it reads 0x30, and its other bits always read zero.
- R3: Control register B is at address 1. Bits 2:1 hold the subsystem divide code and bit 3 selects the slow source when set. After writing 0xFF it reads 0x0E, and its other bits always read zero.
- R4: Divide codes map 0, 1, 2, 3 to ratios 1, 2, 4, 8. The auxiliary strobe is one cycle wide. Once settled, consecutive auxiliary strobes are spaced by exactly the slow period times the ratio, counted in main cycles.
- R5: With bit 3 of register B set, the subsystem strobe is spaced by exactly the slow period times its own ratio.
- R6: With the main-clock source and code 0, the subsystem strobe is high on every main cycle.
- R7: With the main-clock source and codes 1, 2 and 3, the subsystem strobe is spaced by exactly 2, 4 and 8 cycles. Over 600 cycles this gives 300, 150 and 75 strobes.
- R8: While the run input is low, the freeze flag is high from the next cycle on. Both strobes are low from the cycle after that.
- R9: When the run input returns high, the freeze flag drops on the next cycle and the strobes resume.
- R10: Writes to any address other than 0 and 1 change nothing, and reads from those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_in | input | 1 | Slow crystal clock, asynchronous to clk |
| run_in | input | 1 | Run input; low halts both strobes |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| aux_en | output | 1 | Auxiliary enable strobe |
| sub_en | output | 1 | Subsystem enable strobe |
| freeze_o | output | 1 | Freeze flag, high while halted |

## Verification
A wrong divider count or mask shows up at the outputs as a strobe spacing that differs from the ratio. The main-clock source shows it within 8 cycles. The slow source shows it within one slow period times the ratio. A stuck synchroniser or edge detector shows up as an auxiliary strobe two cycles wide, or as no strobes at all. A wrong run path shows up as a freeze flag that lags the run input, or as a strobe seen in the second frozen cycle. Register decode errors appear on the very next read as stray or missing bits.

// File: rtl/cse_pkg.sv
package cse_pkg;
   localparam int unsigned DATA_W    = 8;
   localparam int unsigned A_DIV_LSB = 4;   // auxiliary divide field position
   localparam int unsigned B_DIV_LSB = 1;   // subsystem divide field position
endpackage

// File: rtl/cse_sync_rise.sv
module cse_sync_rise #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_in};
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cse_divider.sv
module cse_divider #(
   parameter int unsigned DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             event_i,
   input  logic [DIV_W-1:0] code_i,
   output logic             strobe_o
);
   localparam int unsigned CNT_W = (1 << DIV_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(code_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         strobe_o <= 1'b0;
      end else begin
         if (event_i) cnt <= cnt + 1'b1;
         strobe_o <= event_i && ((cnt & mask) == '0);
      end
   end
endmodule

// File: rtl/cse_regs.sv
module cse_regs
   import cse_pkg::*;
#(
   parameter int unsigned DIV_W  = 2,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned A_ADDR = 0,
   parameter int unsigned B_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DIV_W-1:0]  a_div,
   output logic [DIV_W-1:0]  b_div,
   output logic              b_sel
);
   localparam int unsigned B_SEL_BIT = B_DIV_LSB + DIV_W;

   logic hit_a, hit_b;
   assign hit_a = (addr == ADDR_W'(A_ADDR));
   assign hit_b = (addr == ADDR_W'(B_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_div <= '0;
         b_div <= '0;
         b_sel <= 1'b0;
      end else if (we) begin
         if (hit_a) a_div <= wdata[A_DIV_LSB +: DIV_W];
         if (hit_b) begin
            b_div <= wdata[B_DIV_LSB +: DIV_W];
            b_sel <= wdata[B_SEL_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_a) rdata[A_DIV_LSB +: DIV_W] = a_div;
      if (hit_b) begin
         rdata[B_DIV_LSB +: DIV_W] = b_div;
         rdata[B_SEL_BIT]          = b_sel;
      end
   end
endmodule

// File: rtl/clk_strobe_gen.sv
module clk_strobe_gen
   import cse_pkg::*;
#(
   parameter int unsigned DIV_W       = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned A_ADDR      = 0,
   parameter int unsigned B_ADDR      = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk_in,
   input  logic              run_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              aux_en,
   output logic              sub_en,
   output logic              freeze_o
);
   localparam int unsigned NCH = 2;   // channel 0 auxiliary, 1 subsystem

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
      $error("DIV_W must be 1..4");
   end
   if (A_DIV_LSB + DIV_W > DATA_W || B_DIV_LSB + DIV_W + 1 > DATA_W) begin : g_bad_field
      $error("divide fields do not fit the register width");
   end
   if (A_ADDR == B_ADDR || A_ADDR >= (1 << ADDR_W) || B_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses clash or exceed ADDR_W");
   end

   logic             run_q;
   logic             slow_rise;
   logic [DIV_W-1:0] a_div, b_div;
   logic             b_sel;
   logic             ev     [NCH];
   logic [DIV_W-1:0] code   [NCH];
   logic             strobe [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_in;
   end
   assign freeze_o = ~run_q;

   cse_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(slow_clk_in), .rise_o(slow_rise)
   );

   cse_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .A_ADDR(A_ADDR), .B_ADDR(B_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .a_div(a_div), .b_div(b_div), .b_sel(b_sel)
   );

   assign ev[0]   = run_q & slow_rise;
   assign ev[1]   = run_q & (b_sel ? slow_rise : 1'b1);
   assign code[0] = a_div;
   assign code[1] = b_div;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cse_divider #(.DIV_W(DIV_W)) u_div (
         .clk(clk), .rst_n(rst_n), .event_i(ev[c]), .code_i(code[c]), .strobe_o(strobe[c])
      );
   end

   assign aux_en = strobe[0];
   assign sub_en = strobe[1];
endmodule

// File: rtl/cse_chk.sv
module cse_chk
   import cse_pkg::*;
#(
   parameter int unsigned DIV_W  = 2,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned A_ADDR = 0,
   parameter int unsigned B_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_in,
   input logic              run_q,
   input logic              b_sel,
   input logic [DIV_W-1:0]  b_div,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_rdata,
   input logic              aux_en,
   input logic              sub_en,
   input logic              freeze_o
);
   localparam logic [7:0] A_MASK = 8'(((1 << DIV_W) - 1) << A_DIV_LSB);
   localparam logic [7:0] B_MASK = 8'(((1 << (DIV_W + 1)) - 1) << B_DIV_LSB);

   p_freeze_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_in |=> freeze_o);
   p_frozen_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_o && $past(freeze_o)) |-> (!aux_en && !sub_en));
   p_freeze_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_in |=> !freeze_o);
   p_aux_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      aux_en |=> !aux_en);
   p_sub_every_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !b_sel && b_div == '0) |=> sub_en);
   p_a_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(A_ADDR)) |-> ((reg_rdata & ~A_MASK) == 8'h00));
   p_b_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(B_ADDR)) |-> ((reg_rdata & ~B_MASK) == 8'h00));
   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != ADDR_W'(A_ADDR) && reg_addr != ADDR_W'(B_ADDR)) |-> (reg_rdata == 8'h00));
endmodule

bind clk_strobe_gen cse_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .A_ADDR(A_ADDR), .B_ADDR(B_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_in(run_in), .run_q(run_q), .b_sel(b_sel), .b_div(b_div),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .aux_en(aux_en), .sub_en(sub_en),
   .freeze_o(freeze_o)
);

// File: tb/sim_clk_strobe_gen.sv
module sim_clk_strobe_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_clk_in = 1'b0;
   logic       run_in = 1'b1;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       aux_en, sub_en, freeze_o;

   int errors = 0;
   int checks = 0;
   int half   = 8;     // slow clock half period in main cycles

   clk_strobe_gen u0 (
      .clk(clk), .rst_n(rst_n), .slow_clk_in(slow_clk_in), .run_in(run_in),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .aux_en(aux_en), .sub_en(sub_en), .freeze_o(freeze_o)
   );

   initial forever #2 clk = ~clk;   // 250 MHz

   initial forever begin
      repeat (half) @(negedge clk);
      slow_clk_in = ~slow_clk_in;
   end

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int ratio(input int code);
      return 1 << code;
   endfunction

   function automatic int exp_gap(input bit slow_src, input int code, input int hp);
      return slow_src ? 2 * hp * ratio(code) : ratio(code);
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = 4'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   // skips two strobes, then checks the spacing of the next npulse gaps
   task automatic gap_check(input bit which, input int gap, input int npulse, input string tag);
      int cyc = 0, last = -1, seen = 0, bad = 0, bad_val = 0;
      int lim = gap * (npulse + 4) + 100;
      while (seen < npulse + 3 && cyc < lim) begin
         @(negedge clk);
         cyc++;
         if (which ? aux_en : sub_en) begin
            seen++;
            if (seen > 2 && (cyc - last) != gap) begin bad++; bad_val = cyc - last; end
            last = cyc;
         end
      end
      if (seen < npulse + 3) chk(1'b0, {tag, " strobe count"}, seen, npulse + 3);
      else chk(bad == 0, {tag, " spacing"}, (bad == 0) ? gap : bad_val, gap);
   endtask

   // counts subsystem strobes in the 600 cycles that follow one strobe
   task automatic window_count(input int expct, input string tag);
      int n = 0, guard = 0;
      while (!sub_en && guard < 100) begin @(negedge clk); guard++; end
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (sub_en) n++;
      end
      chk(n == expct, tag, n, expct);
   endtask

   initial begin
      int d;
      int seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!aux_en && !sub_en, "R1 strobes low in reset", aux_en + sub_en, 0);
      rd(0, d); chk(d == 0, "R1 reg A reset", d, 0);
      rd(1, d); chk(d == 0, "R1 reg B reset", d, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (4) @(negedge clk);
      rd(0, d); chk(d == 0, "R1 reg A after reset", d, 0);

      // R2 / R3 readback of implemented bits
      wr(0, 8'hFF); rd(0, d); chk(d == 8'h30, "R2 reg A readback", d, 8'h30);
      wr(1, 8'hFF); rd(1, d); chk(d == 8'h0E, "R3 reg B readback", d, 8'h0E);

      // R10 unmapped address
      wr(0, 8'h10); wr(1, 8'h04);
      wr(2, 8'hFF); wr(7, 8'h00);
      rd(2, d); chk(d == 0, "R10 unmapped read", d, 0);
      rd(0, d); chk(d == 8'h10, "R10 reg A untouched", d, 8'h10);
      rd(1, d); chk(d == 8'h04, "R10 reg B untouched", d, 8'h04);

      // R6 / R7 main-clock source
      wr(1, 8'h00);
      gap_check(1'b0, 1, 20, "R6 fast div1");
      window_count(600, "R6 fast div1 window");
      for (int c = 1; c < 4; c++) begin
         wr(1, c << 1);
         gap_check(1'b0, ratio(c), 6, "R7 fast div");
         window_count(600 / ratio(c), "R7 fast window");
      end

      // R4 auxiliary, R5 subsystem from slow input, half = 8
      for (int c = 0; c < 4; c++) begin
         wr(0, c << 4);
         gap_check(1'b1, exp_gap(1'b1, c, half), 3, "R4 aux slow");
         wr(1, 8'h08 | (c << 1));
         gap_check(1'b0, exp_gap(1'b1, c, half), 3, "R5 sub slow");
      end

      // R8 / R9 halt and resume
      wr(0, 8'h00); wr(1, 8'h00);
      repeat (40) @(negedge clk);
      run_in = 1'b0;
      repeat (2) @(negedge clk);
      chk(freeze_o == 1'b1, "R8 freeze raised", freeze_o, 1);
      begin
         int n = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (aux_en || sub_en) n++;
            if (!freeze_o) n++;
         end
         chk(n == 0, "R8 strobes stopped", n, 0);
      end
      run_in = 1'b1;
      @(negedge clk);
      chk(freeze_o == 1'b0, "R9 freeze dropped", freeze_o, 0);
      @(negedge clk);
      chk(sub_en == 1'b1, "R9 sub resumes", sub_en, 1);
      gap_check(1'b1, 2 * half, 2, "R9 aux resumes");

      // constrained random configurations
      for (int it = 0; it < 10; it++) begin
         int ac, bc, hp;
         bit bs;
         hp = int'($urandom_range(2, 9));
         ac = int'($urandom_range(0, 3));
         bc = int'($urandom_range(0, 3));
         bs = 1'($urandom_range(0, 1));
         half = hp;
         repeat (40) @(negedge clk);
         wr(0, (ac << 4) | int'($urandom_range(0, 255) & 8'hCF));
         wr(1, (int'(bs) << 3) | (bc << 1) | int'($urandom_range(0, 255) & 8'hF1));
         rd(0, d); chk(d == (ac << 4), "R2 random reg A", d, ac << 4);
         gap_check(1'b1, exp_gap(1'b1, ac, hp), 3, "R4 random aux");
         gap_check(1'b0, exp_gap(bs, bc, hp), 3, bs ? "R5 random sub" : "R7 random sub");
      end

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end
endmodule